// File: doc/BRIEF.md
# Scanline-Counting Interrupt Generator

This block raises a level interrupt toward the CPU after a programmed number of visible scanlines. Software sets the countdown value directly or through a reload value, then arms the block. A separate line detector delivers one pulse per scanline together with that line's number. A flag from the video side says whether rendering is active.

When the countdown reaches zero on a qualifying line, the block raises its interrupt output and marks a request as pending. It also refills the countdown from the reload value. While the request is pending the countdown is frozen. Any write to one of the four interrupt registers clears the pending mark. Only a disarm write lowers the interrupt output.

The countdown has two quirks. On line 0 a nonzero count loses one extra step. The step that reloads the count also decrements it, so a reload value L produces the next interrupt after L further lines, and 256 lines when L is 0.

Top module: `scanline_irq`

## Requirements
- R1: After reset the interrupt output is low, the block is disarmed, nothing is pending, and the countdown and reload value are both zero, so line pulses cause no interrupt until the block is armed.
- R2: A register write is decoded from address bits {A15,A14,A13,A0}. 1100 loads the countdown, 1101 loads the reload value, 1110 disarms and 1111 arms. Every other combination has no effect.
- R3: Writes to the countdown or the reload value clear the pending mark and leave the interrupt output unchanged.
- R4: A disarm write clears the armed state and the pending mark, and the interrupt output is low from the following clock edge.
- R5: An arm write sets the armed state and clears the pending mark, and leaves an asserted interrupt output high.
- R6: A line pulse takes a step only when the line number is at most 239, rendering is enabled, the block is armed and no request is pending. Otherwise the countdown is unchanged.
- R7: On a step at line 0, a nonzero countdown is first reduced by one.
- R8: On a step, if the (possibly reduced) countdown is zero, the block sets the pending mark, asserts the interrupt output at that clock edge, and loads the countdown with the reload value minus one, modulo 256.
- R9: On a step where the countdown is not zero, it is reduced by one. A countdown of N, loaded and then stepped on lines other than 0, interrupts on the (N+1)-th step.
- R10: A line pulse in the same cycle as a write to any of the four interrupt registers takes no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU register write strobe, one cycle |
| wr_a15 | input | 1 | Address bit 15 of the write |
| wr_a14 | input | 1 | Address bit 14 of the write |
| wr_a13 | input | 1 | Address bit 13 of the write |
| wr_a0 | input | 1 | Address bit 0 of the write |
| wr_data | input | 8 | Write data |
| line_tick | input | 1 | One-cycle pulse per scanline |
| line_num | input | 9 | Number of the scanline for this pulse |
| render_on | input | 1 | Rendering enabled |
| irq | output | 1 | Active-high registered interrupt request |

## Verification
The countdown is not visible at the ports. A wrong count, a missing line-0 step or a bad reload therefore shows only as the interrupt output rising on the wrong line pulse: early or late by the size of the error, at the first interrupt after the fault. A stuck pending mark or armed state shows as an interrupt that never returns after acknowledgement. Steps taken when they should not be show as interrupts that come too early. So each check loads a known count, applies a stimulus, and then measures the exact number of line pulses until the interrupt output rises.

// File: rtl/scanline_irq.sv
module scanline_irq #(
  parameter int DW        = 8,
  parameter int LW        = 9,
  parameter int LAST_LINE = 239
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_a15,
  input  logic          wr_a14,
  input  logic          wr_a13,
  input  logic          wr_a0,
  input  logic [DW-1:0] wr_data,
  input  logic          line_tick,
  input  logic [LW-1:0] line_num,
  input  logic          render_on,
  output logic          irq
);

  localparam logic [DW-1:0] ONE  = DW'(1);
  localparam logic [LW-1:0] LAST = LW'(LAST_LINE);

  logic [DW-1:0] cnt, latch, pre, nxt;
  logic          armed, pend;

  wire grp     = wr_en & wr_a15 & wr_a14;
  wire wr_cnt  = grp & ~wr_a13 & ~wr_a0;
  wire wr_lat  = grp & ~wr_a13 &  wr_a0;
  wire wr_off  = grp &  wr_a13 & ~wr_a0;
  wire wr_on   = grp &  wr_a13 &  wr_a0;
  wire irq_wr  = grp;

  wire step = line_tick & (line_num <= LAST) & render_on & armed & ~pend & ~irq_wr;

  assign pre  = (line_num == '0 && cnt != '0) ? cnt - ONE : cnt;
  wire   zero = (pre == '0);
  assign nxt  = (zero ? latch : pre) - ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      latch <= '0;
      armed <= 1'b0;
      pend  <= 1'b0;
      irq   <= 1'b0;
    end else if (irq_wr) begin
      pend <= 1'b0;
      if (wr_cnt) cnt   <= wr_data;
      if (wr_lat) latch <= wr_data;
      if (wr_off) begin
        armed <= 1'b0;
        irq   <= 1'b0;
      end
      if (wr_on) armed <= 1'b1;
    end else if (step) begin
      cnt <= nxt;
      if (zero) begin
        pend <= 1'b1;
        irq  <= 1'b1;
      end
    end
  end

  AST_RISE_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(line_tick) && $past(render_on) && $past(line_num) <= LAST) // R6
    else $error("irq rose without a qualifying line");
  AST_RISE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> pend) // R8
    else $error("irq rose without pending mark");
  AST_OFF_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_off) |-> !irq && !armed && !pend) // R4
    else $error("disarm did not drop irq");
  AST_ON_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_on) && $past(irq) |-> irq && armed) // R5
    else $error("arm dropped irq");
  AST_PEND_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pend) && !$past(irq_wr) |-> $stable(cnt)) // R6
    else $error("count moved while pending");
  AST_WRITE_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_cnt || wr_lat) |-> !pend && irq == $past(irq)) // R3
    else $error("count or reload write mishandled pending");
  AST_WRITE_BLOCKS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_lat || wr_on) |-> $stable(cnt)) // R10
    else $error("step taken during register write");

endmodule

// File: tb/scanline_irq_test.sv
module scanline_irq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_a15 = 1'b0, wr_a14 = 1'b0, wr_a13 = 1'b0, wr_a0 = 1'b0;
  logic [7:0] wr_data = '0;
  logic       line_tick = 1'b0;
  logic [8:0] line_num = '0;
  logic       render_on = 1'b1;
  logic       irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  scanline_irq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_a15(wr_a15), .wr_a14(wr_a14),
    .wr_a13(wr_a13), .wr_a0(wr_a0), .wr_data(wr_data), .line_tick(line_tick),
    .line_num(line_num), .render_on(render_on), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [7:0] d);
    @(negedge clk);
    {wr_a15, wr_a14, wr_a13, wr_a0} = sel;
    wr_data = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick(input int ln);
    @(negedge clk);
    line_num = 9'(ln);
    line_tick = 1'b1;
    @(negedge clk);
    line_tick = 1'b0;
  endtask

  task automatic tick_wr(input int ln, input logic [3:0] sel, input logic [7:0] d);
    @(negedge clk);
    line_num = 9'(ln);
    line_tick = 1'b1;
    {wr_a15, wr_a14, wr_a13, wr_a0} = sel;
    wr_data = d;
    wr_en = 1'b1;
    @(negedge clk);
    line_tick = 1'b0;
    wr_en = 1'b0;
  endtask

  task automatic measure(input int first_ln, output int n);
    n = 0;
    for (int i = 1; i <= 300; i++) begin
      tick(i == 1 ? first_ln : 1);
      if (irq) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic load(input int cnt, input int lat);
    wr(4'b1101, 8'(lat));
    wr(4'b1100, 8'(cnt));
    wr(4'b1111, 8'h00);
  endtask

  task automatic ack();
    wr(4'b1110, 8'h00);
    wr(4'b1111, 8'h00);
  endtask

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    int lats[5] = '{0, 1, 2, 7, 100};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq after reset", irq, 0);
    for (int i = 0; i < 5; i++) tick(1);
    check("R1 disarmed after reset", irq, 0);

    // R9 R8: countdown sweep on lines other than 0
    for (int c = 0; c < 26; c++) begin
      wr(4'b1110, 8'h00);
      load(c, 10);
      measure(1, n);
      check("R9 fire step", n, c + 1);
    end
    wr(4'b1110, 8'h00);
    load(255, 10);
    measure(1, n);
    check("R9 fire step 255", n, 256);

    // R8: reload from latch, decremented in the same step
    foreach (lats[k]) begin
      wr(4'b1110, 8'h00);
      load(0, lats[k]);
      measure(1, n);
      check("R8 first fire", n, 1);
      ack();
      measure(1, n);
      check("R8 reload period", n, lats[k] == 0 ? 256 : lats[k]);
    end

    // R7: extra step on line 0
    for (int c = 0; c < 8; c++) begin
      wr(4'b1110, 8'h00);
      load(c, 10);
      measure(0, n);
      check("R7 line0 fire step", n, c < 2 ? 1 : c);
    end

    // R6: lines above 239, rendering off, disarmed, pending
    wr(4'b1110, 8'h00);
    load(3, 10);
    for (int ln = 240; ln < 262; ln++) tick(ln);
    check("R6 no irq on hidden lines", irq, 0);
    measure(1, n);
    check("R6 hidden lines ignored", n, 4);

    wr(4'b1110, 8'h00);
    load(3, 10);
    render_on = 1'b0;
    for (int i = 0; i < 10; i++) tick(1);
    render_on = 1'b1;
    measure(1, n);
    check("R6 render off ignored", n, 4);

    wr(4'b1110, 8'h00);
    load(3, 10);
    wr(4'b1110, 8'h00);
    for (int i = 0; i < 10; i++) tick(1);
    check("R6 no irq while disarmed", irq, 0);
    wr(4'b1111, 8'h00);
    measure(1, n);
    check("R6 disarmed ignored", n, 4);

    wr(4'b1110, 8'h00);
    load(0, 6);
    measure(1, n);
    for (int i = 0; i < 30; i++) tick(1);
    ack();
    measure(1, n);
    check("R6 pending freezes count", n, 6);

    // R4 / R5 on an asserted irq
    wr(4'b1110, 8'h00);
    load(0, 6);
    measure(1, n);
    wr(4'b1111, 8'h00);
    check("R5 arm keeps irq", irq, 1);
    wr(4'b1110, 8'h00);
    check("R4 disarm drops irq", irq, 0);

    // R3: count write clears pending, irq kept
    load(0, 6);
    measure(1, n);
    wr(4'b1100, 8'd3);
    check("R3 count write keeps irq", irq, 1);
    wr(4'b1101, 8'd6);
    check("R3 reload write keeps irq", irq, 1);
    tick(1);
    tick(1);
    ack();
    measure(1, n);
    check("R3 pending cleared by write", n, 2);

    // R2: other address combinations ignored
    wr(4'b1110, 8'h00);
    load(5, 10);
    for (int s = 0; s < 12; s++) wr(4'(s), 8'h00);
    measure(1, n);
    check("R2 other addresses ignored", n, 6);

    // R10: write in the same cycle as a line pulse blocks the step
    wr(4'b1110, 8'h00);
    load(3, 10);
    tick_wr(1, 4'b1101, 8'd10);
    tick_wr(1, 4'b1111, 8'd0);
    measure(1, n);
    check("R10 write blocks step", n, 4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule